// File: doc/BRIEF.md
# Multi-Module Interrupt Control Unit

This block collects interrupt sources into banks ("modules") of `SRC_W` bits, each with its own window of control registers and its own request line toward the processor. A source is latched as pending when it rises. Software handles pending sources through a simple read/write register port:

- it enables or blocks each source;
- it clears pending bits by writing ones;
- it can re-raise chosen sources through a resend register.

Each module ANDs its pending bits with its enable bits to form an output status. The module's request line is high while that output status is nonzero. The module also reports the index of the highest set output bit, because only that bit is trusted as the active source.

The register port is flat. Module `m` occupies a 40-byte window starting at address `m*40`. Reads are combinational, and a write takes effect at the clock edge where `reg_wr_i` is sampled high.

Top module: `icu_top`

## Requirements
- R1: Module m decodes addresses m*40 to m*40+39. Inside a window the offsets are: 0x00 pending status, 0x08 enable, 0x10 output status, 0x18 resend, 0x20 mask. Any other address reads 0, and a write to it changes nothing.
- R2: A pending bit is set at the first clock edge that samples its source high after the source was low. A source held high does not set the bit again after it is cleared.
- R3: Writing 1 to a pending-status bit clears it, and writing 0 leaves it unchanged. A source rising in the same cycle as a clear of the same bit leaves the bit set.
- R4: The enable register is read/write. Output status reads pending AND enable, and a write to the output-status offset has no effect.
- R5: `irq_o[m]` is high exactly when module m's output status is nonzero.
- R6: `irq_idx_o[m*IDX_W +: IDX_W]` is the bit position of the most significant set output-status bit of module m, and is 0 when none is set.
- R7: Writing 1 to a resend bit sets that pending bit at the same clock edge. The resend offset always reads 0.
- R8: The mask register is read/write storage and has no effect on output status or on the request line.
- R9: After reset, pending, enable and mask are all zero, every request line is low and every index is 0.
- R10: Modules are independent. A write into one module's window leaves every other module's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_MOD*SRC_W | Interrupt sources; module m uses bits [m*SRC_W +: SRC_W] |
| reg_addr_i | input | ADDR_W | Byte address of the register access |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | SRC_W | Write data |
| reg_rdata_o | output | SRC_W | Combinational read data for reg_addr_i |
| irq_o | output | NUM_MOD | Per-module request line |
| irq_idx_o | output | NUM_MOD*IDX_W | Per-module index of the highest active source |

## Verification
On every cycle, the assertions check the following:

- a rising source leaves its pending bit set;
- a write-one clear removes the pending bit unless a new edge arrives with it;
- a resend write sets the targeted bits;
- enable writes are retained;
- the request line only rises with a nonzero enable and pending status;
- the reported index is the top set output bit;
- unmapped addresses read zero.

Only the bench scenarios can show the following:

- that the window layout matches the stated offsets;
- that a held-high source does not set its bit again;
- that mask and output-status writes change nothing;
- that one module's traffic leaves the others untouched.

// File: rtl/icu_pkg.sv
package icu_pkg;

    typedef enum logic [2:0] {
        RK_STAT   = 3'd0,
        RK_EN     = 3'd1,
        RK_OUT    = 3'd2,
        RK_RESEND = 3'd3,
        RK_MASK   = 3'd4,
        RK_NONE   = 3'd7
    } reg_kind_e;

    // Byte layout of one module window
    localparam int unsigned WIN_STRIDE = 40;
    localparam int unsigned OFF_STAT   = 0;
    localparam int unsigned OFF_EN     = 8;
    localparam int unsigned OFF_OUT    = 16;
    localparam int unsigned OFF_RESEND = 24;
    localparam int unsigned OFF_MASK   = 32;

endpackage

// File: rtl/icu_addr_dec.sv
module icu_addr_dec
    import icu_pkg::*;
#(
    parameter int unsigned NUM_MOD = 5,
    parameter int unsigned ADDR_W  = 12
) (
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [NUM_MOD-1:0] hit_o,
    output reg_kind_e          kind_o
);

    logic [31:0] addr_w;
    logic [31:0] off;
    logic        any_hit;

    always_comb begin
        addr_w  = 32'(addr_i);
        hit_o   = '0;
        off     = '0;
        any_hit = 1'b0;
        for (int m = 0; m < int'(NUM_MOD); m++) begin
            if (addr_w >= 32'(m * int'(WIN_STRIDE)) &&
                addr_w <  32'((m + 1) * int'(WIN_STRIDE))) begin
                hit_o[m] = 1'b1;
                any_hit  = 1'b1;
                off      = addr_w - 32'(m * int'(WIN_STRIDE));
            end
        end
        kind_o = RK_NONE;
        if (any_hit) begin
            case (off)
                32'(OFF_STAT):   kind_o = RK_STAT;
                32'(OFF_EN):     kind_o = RK_EN;
                32'(OFF_OUT):    kind_o = RK_OUT;
                32'(OFF_RESEND): kind_o = RK_RESEND;
                32'(OFF_MASK):   kind_o = RK_MASK;
                default:         kind_o = RK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/icu_msb_enc.sv
module icu_msb_enc #(
    parameter int unsigned WIDTH = 32,
    localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [IDX_W-1:0] idx_o
);

    // Later (higher) set bits overwrite earlier ones: most significant wins
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < int'(WIDTH); i++) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/icu_bank.sv
module icu_bank
    import icu_pkg::*;
#(
    parameter int unsigned SRC_W = 32,
    localparam int unsigned IDX_W = (SRC_W > 1) ? $clog2(SRC_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    input  logic             sel_i,
    input  logic             wr_i,
    input  reg_kind_e        kind_i,
    input  logic [SRC_W-1:0] wdata_i,
    output logic [SRC_W-1:0] rdata_o,
    output logic             irq_o,
    output logic [IDX_W-1:0] idx_o
);

    typedef struct packed {
        logic [SRC_W-1:0] status;
        logic [SRC_W-1:0] enable;
        logic [SRC_W-1:0] mask;
        logic [SRC_W-1:0] src_prev;
    } bank_t;

    bank_t            st_d, st_q;
    logic             wr_hit;
    logic [SRC_W-1:0] rise;
    logic [SRC_W-1:0] clr;
    logic [SRC_W-1:0] rsnd;
    logic [SRC_W-1:0] outstat;

    always_comb begin
        st_d   = st_q;
        wr_hit = sel_i & wr_i;
        rise   = src_i & ~st_q.src_prev;
        clr    = (wr_hit && kind_i == RK_STAT)   ? wdata_i : '0;
        rsnd   = (wr_hit && kind_i == RK_RESEND) ? wdata_i : '0;
        // a fresh edge or a resend outranks a clear of the same bit
        st_d.status = (st_q.status & ~clr) | rise | rsnd;
        if (wr_hit && kind_i == RK_EN)   st_d.enable = wdata_i;
        if (wr_hit && kind_i == RK_MASK) st_d.mask   = wdata_i;
        st_d.src_prev = src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign outstat = st_q.status & st_q.enable;
    assign irq_o   = |outstat;

    icu_msb_enc #(.WIDTH(SRC_W)) enc_i (
        .vec_i (outstat),
        .idx_o (idx_o)
    );

    always_comb begin
        rdata_o = '0;
        if (sel_i) begin
            case (kind_i)
                RK_STAT: rdata_o = st_q.status;
                RK_EN:   rdata_o = st_q.enable;
                RK_OUT:  rdata_o = outstat;
                RK_MASK: rdata_o = st_q.mask;
                default: rdata_o = '0;
            endcase
        end
    end

    // R2
    edge_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((st_q.status & $past(rise)) == $past(rise)));

    // R3
    clear_removes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && kind_i == RK_STAT) |=> ((st_q.status & $past(wdata_i & ~rise)) == '0));

    // R4
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && kind_i == RK_EN) |=> (st_q.enable == $past(wdata_i)));

    // R5
    irq_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (st_q.enable != '0 && st_q.status != '0));

    // R6
    idx_is_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((outstat >> idx_o) == SRC_W'(1)));

    // R7
    resend_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && kind_i == RK_RESEND) |=> ((st_q.status & $past(wdata_i)) == $past(wdata_i)));

endmodule

// File: rtl/icu_top.sv
module icu_top
    import icu_pkg::*;
#(
    parameter int unsigned NUM_MOD = 5,
    parameter int unsigned SRC_W   = 32,
    parameter int unsigned ADDR_W  = 12,
    localparam int unsigned IDX_W  = (SRC_W > 1) ? $clog2(SRC_W) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_MOD*SRC_W-1:0] src_i,
    input  logic [ADDR_W-1:0]        reg_addr_i,
    input  logic                     reg_wr_i,
    input  logic [SRC_W-1:0]         reg_wdata_i,
    output logic [SRC_W-1:0]         reg_rdata_o,
    output logic [NUM_MOD-1:0]       irq_o,
    output logic [NUM_MOD*IDX_W-1:0] irq_idx_o
);

    logic [NUM_MOD-1:0] hit;
    reg_kind_e          kind;
    logic [SRC_W-1:0]   bank_rd [NUM_MOD];

    icu_addr_dec #(.NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W)) dec_i (
        .addr_i (reg_addr_i),
        .hit_o  (hit),
        .kind_o (kind)
    );

    for (genvar m = 0; m < int'(NUM_MOD); m++) begin : g_bank
        icu_bank #(.SRC_W(SRC_W)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_i[m*SRC_W +: SRC_W]),
            .sel_i   (hit[m]),
            .wr_i    (reg_wr_i),
            .kind_i  (kind),
            .wdata_i (reg_wdata_i),
            .rdata_o (bank_rd[m]),
            .irq_o   (irq_o[m]),
            .idx_o   (irq_idx_o[m*IDX_W +: IDX_W])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        for (int m = 0; m < int'(NUM_MOD); m++) reg_rdata_o |= bank_rd[m];
    end

    // R1
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RK_NONE) |-> (reg_rdata_o == '0));

endmodule

// File: tb/icu_top_tb_top.sv
module icu_top_tb_top;

    localparam int NM = 5;
    localparam int SW = 32;
    localparam int IW = 5;
    localparam int AW = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NM*SW-1:0] src = '0;
    logic [AW-1:0]    reg_addr = '0;
    logic             reg_wr = 1'b0;
    logic [SW-1:0]    reg_wdata = '0;
    logic [SW-1:0]    reg_rdata;
    logic [NM-1:0]    irq;
    logic [NM*IW-1:0] irq_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // scoreboard queues: kind 0 = read data, 1 = irq vector, 2 = index of module
    int          kq[$];
    int          mq[$];
    logic [31:0] eq[$];
    string       tq[$];

    always #5 clk = ~clk;

    icu_top #(.NUM_MOD(NM), .SRC_W(SW), .ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .reg_addr_i  (reg_addr),
        .reg_wr_i    (reg_wr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq),
        .irq_idx_o   (irq_idx)
    );

    function automatic int win(int m, int off);
        return m * 40 + off;
    endfunction

    // driver: stage a check and push its expectation
    task automatic expect_item(int kind, int m, int addr, logic [31:0] exp, string tag);
        @(negedge clk);
        reg_wr = 1'b0;
        if (kind == 0) reg_addr = AW'(addr);
        kq.push_back(kind);
        mq.push_back(m);
        eq.push_back(exp);
        tq.push_back(tag);
    endtask

    task automatic wr(int addr, logic [31:0] d);
        @(negedge clk);
        reg_addr  = AW'(addr);
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic set_src(int m, logic [31:0] v);
        @(negedge clk);
        src[m*SW +: SW] = v;
        @(posedge clk);
        #1;
    endtask

    // monitor: pop one expectation per cycle and compare
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (kq.size() > 0) begin
                int          k;
                int          m;
                logic [31:0] e;
                logic [31:0] a;
                string       t;
                k = kq.pop_front();
                m = mq.pop_front();
                e = eq.pop_front();
                t = tq.pop_front();
                if (k == 0)      a = reg_rdata;
                else if (k == 1) a = 32'(irq);
                else             a = 32'(irq_idx[m*IW +: IW]);
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9 reset state
        expect_item(0, 0, win(0, 0),  32'h0, "R9 status m0");
        expect_item(0, 0, win(0, 8),  32'h0, "R9 enable m0");
        expect_item(0, 0, win(4, 32), 32'h0, "R9 mask m4");
        expect_item(1, 0, 0, 32'h0, "R9 irq vector");
        expect_item(2, 3, 0, 32'h0, "R9 index m3");

        // R2 edges latch; R4/R5 nothing out while disabled
        set_src(0, 32'h0002_0008);
        expect_item(0, 0, win(0, 0),  32'h0002_0008, "R2 status after edges");
        expect_item(0, 0, win(0, 16), 32'h0, "R4 out with enable 0");
        expect_item(1, 0, 0, 32'h0, "R5 irq low while disabled");

        // R4/R5/R6 enable all
        wr(win(0, 8), 32'hFFFF_FFFF);
        expect_item(0, 0, win(0, 8),  32'hFFFF_FFFF, "R4 enable readback");
        expect_item(0, 0, win(0, 16), 32'h0002_0008, "R4 out status");
        expect_item(1, 0, 0, 32'h1, "R5 irq m0 high");
        expect_item(2, 0, 0, 32'd17, "R6 top index 17");

        // R4 output status is read-only
        wr(win(0, 16), 32'h0);
        expect_item(0, 0, win(0, 16), 32'h0002_0008, "R4 out write ignored");

        // R3 clear bit 17, R2 held source does not re-set
        wr(win(0, 0), 32'h0002_0000);
        expect_item(0, 0, win(0, 0), 32'h0000_0008, "R3 write-one clear");
        expect_item(2, 0, 0, 32'd3, "R6 index falls to 3");

        // R3 writing zero leaves status
        wr(win(0, 0), 32'h0);
        expect_item(0, 0, win(0, 0), 32'h0000_0008, "R3 zero write no effect");

        // R3 edge beats simultaneous clear on bit 5
        @(negedge clk);
        src[5]    = 1'b1;
        reg_addr  = AW'(win(0, 0));
        reg_wdata = 32'h0000_0020;
        reg_wr    = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
        expect_item(0, 0, win(0, 0), 32'h0000_0028, "R3 edge wins over clear");

        // R7 resend
        wr(win(0, 24), 32'h8000_0000);
        expect_item(0, 0, win(0, 0),  32'h8000_0028, "R7 resend sets bit 31");
        expect_item(0, 0, win(0, 24), 32'h0, "R7 resend reads zero");
        expect_item(2, 0, 0, 32'd31, "R6 index 31");

        // R8 mask is storage only
        wr(win(0, 32), 32'hA5A5_0000);
        expect_item(0, 0, win(0, 32), 32'hA5A5_0000, "R8 mask readback");
        expect_item(0, 0, win(0, 16), 32'h8000_0028, "R8 mask no effect");

        // R10 module 2 independent
        expect_item(0, 0, win(2, 0), 32'h0, "R10 m2 status untouched");
        wr(win(2, 8), 32'h0000_0001);
        set_src(2, 32'h0000_0001);
        expect_item(1, 0, 0, 32'h5, "R10 irq m0 and m2");
        expect_item(2, 2, 0, 32'd0, "R10 m2 index 0");
        expect_item(0, 0, win(0, 8), 32'hFFFF_FFFF, "R10 m0 enable kept");

        // R1 layout and unmapped addresses
        wr(win(1, 4), 32'h0000_DEAD);
        expect_item(0, 0, win(1, 4), 32'h0, "R1 unmapped offset 4");
        wr(win(1, 8), 32'h0000_00F0);
        expect_item(0, 0, win(1, 8), 32'h0000_00F0, "R1 m1 enable at 0x30");
        expect_item(0, 0, win(0, 8), 32'hFFFF_FFFF, "R1 m0 enable separate");
        expect_item(0, 0, 200, 32'h0, "R1 past last window");
        expect_item(0, 0, 38,  32'h0, "R1 gap offset 0x26");

        // R5/R6 clear all of m0; held sources stay cleared
        wr(win(0, 0), 32'hFFFF_FFFF);
        expect_item(0, 0, win(0, 0), 32'h0, "R2 held sources no re-set");
        expect_item(1, 0, 0, 32'h4, "R5 irq m0 low");
        expect_item(2, 0, 0, 32'd0, "R6 index 0 when empty");

        repeat (4) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule